// File: doc/BRIEF.md
# Dual-Bank Glitch-Free Rate Switcher

This block retunes a divided clock-enable stream without producing a runt or glitched pulse at its output. It keeps two complete divider configurations, called banks. Each bank has a source code, a pre-divide value and an M/N fraction. A single select bit names the bank that feeds the output. A glitch-free two-way mux chooses between that bank's tick stream and an always-running reference tick.

A new configuration arrives on a valid/ready port, one beat per update. The sequencer first parks the mux on the reference. It then programs a bank in a fixed order. When the output is enabled it writes the idle bank and swaps banks on a tick boundary of the outgoing bank. When the output is disabled it rewrites the selected bank in place. The mux returns to the divided path only when the output is enabled and the active bank is actually ticking, so the mux can never wait on a dead clock. The divider datapath is modelled as one clock-enable tick generator per bank.

Top module: `dualbank_rate_sw`

## Requirements
- R1: After reset the select bit is 0, the mux is on the reference (`mux_on_mn`=0), `upd_ready`=1, `act_src_idx`=0 and `out_tick` follows `ref_tick`.
- R2: An update is taken in a cycle with `upd_valid` and `upd_ready` both high. `upd_ready` is low from the next cycle until the sequence ends, and a beat offered while `upd_ready` is low is dropped with no effect.
- R3: If `out_en` is high when an update is taken, every write goes to the bank not selected and the select bit toggles once. If `out_en` is low, the writes go to the selected bank and the select bit does not change.
- R4: Bank programming order is: set the counter reset, write M and N, write the fraction-mode bit (on when N is nonzero), clear the reset, then write pre-divide and source code. M and N are written only while the reset is set, and pre-divide and source are written only after it is cleared.
- R5: A running bank gives one pre-tick per (pre+1) source ticks. With N=0 each pre-tick is an output tick. With N nonzero, every N consecutive pre-ticks yield exactly M output ticks (M must not exceed N).
- R6: The source codes are 1, 2, 4 and 6, selecting source index 0, 1, 2 and 3. Any other code selects index 0. `act_src_idx` reports the index used by the selected bank.
- R7: The two mux gates are never on together. A switch turns the old side off one edge after the request and the new side on at the third edge. `out_tick` is 0 while both sides are off.
- R8: Before the first register write of an update, the mux is on the reference. After the update it returns to the divided path only if `out_en` is high and the new active bank has produced a tick, and `upd_ready` rises only once that switch is complete.
- R9: The select bit changes only on the clock edge that follows a tick of the outgoing bank.
- R10: While no update is running, raising `out_en` moves the mux to the divided path once the active bank has ticked. Lowering it moves the mux back to the reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_en | input | 1 | Output enabled (divided path wanted) |
| ref_tick | input | 1 | Always-running reference tick |
| src_tick | input | NSRC (4) | Source tick enables, one per source index |
| upd_valid | input | 1 | Update beat valid |
| upd_ready | output | 1 | Update accepted when high with valid |
| upd_src | input | SCW (3) | Source code of the update |
| upd_pre | input | PW (4) | Pre-divide minus one |
| upd_m | input | MNW (8) | Fraction numerator M |
| upd_n | input | MNW (8) | Fraction denominator N, 0 = bypass |
| out_tick | output | 1 | Glitch-free output tick |
| bank_sel | output | 1 | Index of the active bank |
| mux_on_mn | output | 1 | Mux gate on divided path |
| act_src_idx | output | 2 | Source index used by the active bank |

## Verification
Mux results are due at fixed edges after a change of `out_en`. The divided side drops at the first edge, and the new side opens at the third edge. The bench samples on the falling edge after each of those rising edges. An update's `upd_ready` falls one edge after acceptance. Its end depends on the old and new tick streams, so the bench polls `upd_ready` each falling edge. Rate checks do not depend on the accumulator's phase: they take the gap between an output tick and the M-th following one and compare it with N·(pre+1)·P cycles, where P is the source period. The bank swap is checked against the old bank's period: the swap must be seen one cycle after a multiple of that period following the last recorded old tick.

// File: rtl/rsw_pkg.sv
package rsw_pkg;
  parameter int NSRC = 4;
  parameter int IDXW = 2;
  parameter int SCW  = 3;
  parameter int PW   = 4;
  parameter int MNW  = 8;
  parameter int NBANK = 2;

  localparam logic [SCW-1:0] SRC_CODES [NSRC] = '{3'd1, 3'd2, 3'd4, 3'd6};

  typedef struct packed {
    logic [SCW-1:0] src;
    logic [PW-1:0]  pre;
    logic [MNW-1:0] m;
    logic [MNW-1:0] n;
  } rate_cfg_t;

  typedef enum logic [3:0] {
    S_IDLE, S_PARK, S_RSTON, S_WMN, S_WMODE, S_RSTOFF, S_WCFG, S_SWAP, S_WAKE
  } seq_st_t;

  function automatic logic [IDXW-1:0] src_index(input logic [SCW-1:0] code);
    logic [IDXW-1:0] idx;
    logic hit;
    idx = '0;
    hit = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (!hit && code == SRC_CODES[i]) begin
        idx = IDXW'(i);
        hit = 1'b1;
      end
    end
    return idx;
  endfunction
endpackage

// File: rtl/rsw_tickgen.sv
module rsw_tickgen
  import rsw_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold,
  input  logic           src_en,
  input  logic [PW-1:0]  pre,
  input  logic           mn_on,
  input  logic [MNW-1:0] m,
  input  logic [MNW-1:0] n,
  output logic           tick
);
  logic [PW-1:0] pcnt;
  logic [MNW:0]  acc;
  logic [MNW:0]  sum;
  logic          pre_hit;

  assign pre_hit = src_en && (pcnt == pre);
  assign sum     = acc + {1'b0, m};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      acc  <= '0;
      tick <= 1'b0;
    end else if (hold) begin
      pcnt <= '0;
      acc  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (src_en) pcnt <= pre_hit ? '0 : pcnt + 1'b1;
      if (pre_hit) begin
        if (mn_on) begin
          if (sum >= {1'b0, n}) begin
            acc  <= sum - {1'b0, n};
            tick <= 1'b1;
          end else begin
            acc <= sum;
          end
        end else begin
          tick <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rsw_banks.sv
module rsw_banks
  import rsw_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NSRC-1:0]             src_tick,
  input  logic                        wr_bank,
  input  logic                        wr_rst_set,
  input  logic                        wr_mn,
  input  logic                        wr_mode,
  input  logic                        wr_rst_clr,
  input  logic                        wr_cfg,
  input  rate_cfg_t                   wdata,
  output logic [NBANK-1:0]            bank_tick,
  output logic [NBANK-1:0]            bank_rst,
  output logic [NBANK-1:0][IDXW-1:0]  bank_src_idx
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    rate_cfg_t       cfg;
    logic            mn_on;
    logic            hold;
    logic            sel;
    logic [IDXW-1:0] sidx;

    assign sel  = (wr_bank == b[0]);
    assign sidx = src_index(cfg.src);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg.src <= SRC_CODES[0];
        cfg.pre <= '0;
        cfg.m   <= '0;
        cfg.n   <= '0;
        mn_on   <= 1'b0;
        hold    <= 1'b0;
      end else if (sel) begin
        if (wr_rst_set) hold <= 1'b1;
        if (wr_rst_clr) hold <= 1'b0;
        if (wr_mn) begin
          cfg.m <= wdata.m;
          cfg.n <= wdata.n;
        end
        if (wr_mode) mn_on <= (wdata.n != '0);
        if (wr_cfg) begin
          cfg.pre <= wdata.pre;
          cfg.src <= wdata.src;
        end
      end
    end

    rsw_tickgen u_tg (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (hold),
      .src_en(src_tick[sidx]),
      .pre   (cfg.pre),
      .mn_on (mn_on),
      .m     (cfg.m),
      .n     (cfg.n),
      .tick  (bank_tick[b])
    );

    assign bank_rst[b]     = hold;
    assign bank_src_idx[b] = sidx;
  end
endmodule

// File: rtl/rsw_gfmux.sv
module rsw_gfmux (
  input  logic clk,
  input  logic rst_n,
  input  logic want_mn,
  output logic gate_ref,
  output logic gate_mn
);
  logic arm_ref, arm_mn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_ref  <= 1'b1;
      gate_ref <= 1'b1;
      arm_mn   <= 1'b0;
      gate_mn  <= 1'b0;
    end else begin
      arm_mn   <= want_mn && !gate_ref;
      gate_mn  <= arm_mn && want_mn;
      arm_ref  <= !want_mn && !gate_mn;
      gate_ref <= arm_ref && !want_mn;
    end
  end
endmodule

// File: rtl/rsw_seq.sv
module rsw_seq
  import rsw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      out_en,
  input  logic      upd_valid,
  input  rate_cfg_t upd_cfg,
  input  logic      gate_ref,
  input  logic      gate_mn,
  input  logic      act_tick,
  output logic      upd_ready,
  output rate_cfg_t cfg_q,
  output logic      en_lat,
  output logic      bank_sel,
  output logic      wr_bank,
  output logic      wr_rst_set,
  output logic      wr_mn,
  output logic      wr_mode,
  output logic      wr_rst_clr,
  output logic      wr_cfg,
  output logic      wr_any,
  output logic      want_mn
);
  seq_st_t st;
  logic    alive;
  logic    swap_now;

  assign upd_ready  = (st == S_IDLE);
  assign wr_bank    = en_lat ? ~bank_sel : bank_sel;
  assign wr_rst_set = (st == S_RSTON);
  assign wr_mn      = (st == S_WMN);
  assign wr_mode    = (st == S_WMODE);
  assign wr_rst_clr = (st == S_RSTOFF);
  assign wr_cfg     = (st == S_WCFG);
  assign wr_any     = wr_rst_set | wr_mn | wr_mode | wr_rst_clr | wr_cfg;
  assign swap_now   = (st == S_SWAP) && act_tick;
  assign want_mn    = ((st == S_IDLE) || (st == S_WAKE)) && out_en && alive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cfg_q    <= '0;
      en_lat   <= 1'b0;
      bank_sel <= 1'b0;
      alive    <= 1'b0;
    end else begin
      if (swap_now || (wr_rst_set && !en_lat)) alive <= 1'b0;
      else if (act_tick)                       alive <= 1'b1;
      unique case (st)
        S_IDLE: if (upd_valid) begin
          cfg_q  <= upd_cfg;
          en_lat <= out_en;
          st     <= S_PARK;
        end
        S_PARK:   if (gate_ref) st <= S_RSTON;
        S_RSTON:  st <= S_WMN;
        S_WMN:    st <= S_WMODE;
        S_WMODE:  st <= S_RSTOFF;
        S_RSTOFF: st <= S_WCFG;
        S_WCFG:   st <= en_lat ? S_SWAP : S_IDLE;
        S_SWAP: if (swap_now) begin
          bank_sel <= ~bank_sel;
          st       <= S_WAKE;
        end
        S_WAKE:   if (!out_en || gate_mn) st <= S_IDLE;
        default:  st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dualbank_rate_sw.sv
module dualbank_rate_sw
  import rsw_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            out_en,
  input  logic            ref_tick,
  input  logic [NSRC-1:0] src_tick,
  input  logic            upd_valid,
  output logic            upd_ready,
  input  logic [SCW-1:0]  upd_src,
  input  logic [PW-1:0]   upd_pre,
  input  logic [MNW-1:0]  upd_m,
  input  logic [MNW-1:0]  upd_n,
  output logic            out_tick,
  output logic            bank_sel,
  output logic            mux_on_mn,
  output logic [IDXW-1:0] act_src_idx
);
  rate_cfg_t                  upd_cfg, cfg_q;
  logic                       en_lat, wr_bank, wr_any, want_mn;
  logic                       wr_rst_set, wr_mn, wr_mode, wr_rst_clr, wr_cfg;
  logic                       gate_ref, gate_mn, act_tick;
  logic [NBANK-1:0]           bank_tick, bank_rst;
  logic [NBANK-1:0][IDXW-1:0] bank_src_idx;

  assign upd_cfg = '{src: upd_src, pre: upd_pre, m: upd_m, n: upd_n};

  rsw_seq u_seq (
    .clk(clk), .rst_n(rst_n), .out_en(out_en), .upd_valid(upd_valid),
    .upd_cfg(upd_cfg), .gate_ref(gate_ref), .gate_mn(gate_mn),
    .act_tick(act_tick), .upd_ready(upd_ready), .cfg_q(cfg_q),
    .en_lat(en_lat), .bank_sel(bank_sel), .wr_bank(wr_bank),
    .wr_rst_set(wr_rst_set), .wr_mn(wr_mn), .wr_mode(wr_mode),
    .wr_rst_clr(wr_rst_clr), .wr_cfg(wr_cfg), .wr_any(wr_any),
    .want_mn(want_mn)
  );

  rsw_banks u_banks (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_bank(wr_bank),
    .wr_rst_set(wr_rst_set), .wr_mn(wr_mn), .wr_mode(wr_mode),
    .wr_rst_clr(wr_rst_clr), .wr_cfg(wr_cfg), .wdata(cfg_q),
    .bank_tick(bank_tick), .bank_rst(bank_rst), .bank_src_idx(bank_src_idx)
  );

  rsw_gfmux u_mux (
    .clk(clk), .rst_n(rst_n), .want_mn(want_mn),
    .gate_ref(gate_ref), .gate_mn(gate_mn)
  );

  assign act_tick    = bank_tick[bank_sel];
  assign act_src_idx = bank_src_idx[bank_sel];
  assign mux_on_mn   = gate_mn;
  assign out_tick    = (gate_mn && act_tick) || (gate_ref && ref_tick);
endmodule

// File: rtl/rsw_checker.sv
module rsw_checker
  import rsw_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             upd_valid,
  input logic             upd_ready,
  input logic             gate_ref,
  input logic             gate_mn,
  input logic             bank_sel,
  input logic             act_tick,
  input logic             en_lat,
  input logic             wr_bank,
  input logic             wr_any,
  input logic             wr_mn,
  input logic             wr_cfg,
  input logic [NBANK-1:0] bank_rst
);
  logic tgt_rst;
  assign tgt_rst = bank_rst[wr_bank];

  assert_mux_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_ref && gate_mn));
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_ready) |=> !upd_ready);
  assert_mn_in_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mn |-> tgt_rst);
  assert_cfg_after_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cfg |-> !tgt_rst);
  assert_write_idle_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && en_lat) |-> (wr_bank != bank_sel));
  assert_write_in_place_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && !en_lat) |-> (wr_bank == bank_sel));
  assert_ref_while_prog_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |-> (gate_ref && !gate_mn));
  assert_swap_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank_sel) |-> $past(act_tick));
endmodule

bind dualbank_rate_sw rsw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_ready(upd_ready),
  .gate_ref(gate_ref), .gate_mn(gate_mn), .bank_sel(bank_sel),
  .act_tick(act_tick), .en_lat(en_lat), .wr_bank(wr_bank), .wr_any(wr_any),
  .wr_mn(wr_mn), .wr_cfg(wr_cfg), .bank_rst(bank_rst)
);

// File: tb/sim_dualbank_rate_sw.sv
`timescale 1ns/1ps
module sim_dualbank_rate_sw;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       out_en = 1'b0;
  logic       ref_tick = 1'b1;
  logic [3:0] src_tick = 4'b0;
  logic       upd_valid = 1'b0;
  logic       upd_ready;
  logic [2:0] upd_src = 3'd1;
  logic [3:0] upd_pre = 4'd0;
  logic [7:0] upd_m = 8'd0;
  logic [7:0] upd_n = 8'd0;
  logic       out_tick, bank_sel, mux_on_mn;
  logic [1:0] act_src_idx;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int last_tick = 0;
  int swap_cyc = -1;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dualbank_rate_sw u0 (
    .clk(clk), .rst_n(rst_n), .out_en(out_en), .ref_tick(ref_tick),
    .src_tick(src_tick), .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_src(upd_src), .upd_pre(upd_pre), .upd_m(upd_m), .upd_n(upd_n),
    .out_tick(out_tick), .bank_sel(bank_sel), .mux_on_mn(mux_on_mn),
    .act_src_idx(act_src_idx)
  );

  // Source i ticks once every i+1 cycles.
  always @(negedge clk)
    for (int i = 0; i < 4; i++) src_tick[i] <= ((cyc % (i + 1)) == 0);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [2:0] code_of(input int idx);
    case (idx)
      0: return 3'd1;
      1: return 3'd2;
      2: return 3'd4;
      default: return 3'd6;
    endcase
  endfunction

  task automatic wait_ready(input logic old_sel);
    int k = 0;
    swap_cyc = -1;
    while (!upd_ready && k < 5000) begin
      @(negedge clk);
      if (bank_sel != old_sel && swap_cyc < 0) swap_cyc = cyc;
      k++;
    end
    chk(upd_ready, "R2 ready returns", upd_ready, 1);
  endtask

  // Offer one beat and check that it is taken and ready drops.
  task automatic send(input logic [2:0] s, input int p, input int m, input int n);
    @(negedge clk);
    upd_src = s; upd_pre = 4'(p); upd_m = 8'(m); upd_n = 8'(n);
    upd_valid = 1'b1;
    @(negedge clk);
    upd_valid = 1'b0;
    chk(!upd_ready, "R2 busy after accept", upd_ready, 0);
  endtask

  // Gap from one output tick to the m-th later one is n*(pre+1)*P.
  task automatic measure(input string req, input int p, input int m, input int n, input int per);
    int t0, k, seen, mm, nn;
    mm = (n == 0) ? 1 : m;
    nn = (n == 0) ? 1 : n;
    k = 0;
    while (!out_tick && k < 2000) begin @(negedge clk); k++; end
    t0 = cyc; seen = 0;
    while (seen < mm && k < 4000) begin
      @(negedge clk); k++;
      if (out_tick) seen++;
    end
    chk((cyc - t0) == nn * (p + 1) * per, req, cyc - t0, nn * (p + 1) * per);
    last_tick = cyc;
  endtask

  initial begin : main
    int mt[4], nt[4];
    int prev_per;
    logic sel0;
    mt = '{0, 1, 1, 3};
    nt = '{0, 2, 3, 16};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bank_sel == 0, "R1 select", bank_sel, 0);
    chk(mux_on_mn == 0, "R1 mux on reference", mux_on_mn, 0);
    chk(upd_ready == 1, "R1 ready", upd_ready, 1);
    chk(act_src_idx == 0, "R1 source index", act_src_idx, 0);
    chk(out_tick == 1, "R1 output follows reference", out_tick, 1);

    // Bank 0 runs bypass from source 0; enable and wait for the divided path.
    out_en = 1'b1;
    repeat (5) @(negedge clk);
    chk(mux_on_mn == 1, "R10 enable reaches divided path", mux_on_mn, 1);
    measure("R5 reset bank rate", 0, 0, 0, 1);
    prev_per = 1;

    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 4; k++)
        for (int i = 0; i < 4; i++) begin
          sel0 = bank_sel;
          send(code_of(i), p, mt[k], nt[k]);
          wait_ready(sel0);
          chk(bank_sel != sel0, "R3 enabled update toggles select", bank_sel, !sel0);
          chk(mux_on_mn == 1, "R8 back on divided path", mux_on_mn, 1);
          chk(act_src_idx == 2'(i), "R6 source index", act_src_idx, i);
          if (prev_per > 0)
            chk(((swap_cyc - 1 - last_tick) % prev_per) == 0, "R9 swap on tick boundary",
                (swap_cyc - 1 - last_tick) % prev_per, 0);
          measure("R4 R5 rate after update", p, mt[k], nt[k], i + 1);
          prev_per = (mt[k] <= 1) ? ((nt[k] == 0 ? 1 : nt[k]) * (p + 1) * (i + 1)) : 0;
        end

    // R10 and R7: drop and raise the enable with exact edge timing.
    @(negedge clk);
    out_en = 1'b0;
    @(negedge clk);
    chk(mux_on_mn == 0, "R10 divided side off at first edge", mux_on_mn, 0);
    chk(out_tick == 0, "R7 silent during switch", out_tick, 0);
    @(negedge clk);
    chk(out_tick == 0, "R7 silent during switch", out_tick, 0);
    @(negedge clk);
    chk(out_tick == 1, "R7 reference on at third edge", out_tick, 1);
    out_en = 1'b1;
    @(negedge clk);
    chk(out_tick == 0, "R7 reference off at first edge", out_tick, 0);
    @(negedge clk);
    chk(mux_on_mn == 0, "R7 divided side not yet on", mux_on_mn, 0);
    @(negedge clk);
    chk(mux_on_mn == 1, "R10 divided side on at third edge", mux_on_mn, 1);

    // R2: beat offered while busy is dropped.
    sel0 = bank_sel;
    send(code_of(1), 1, 1, 2);
    @(negedge clk);
    upd_src = code_of(0); upd_pre = 4'd0; upd_m = 8'd0; upd_n = 8'd0; upd_valid = 1'b1;
    @(negedge clk);
    upd_valid = 1'b0;
    wait_ready(sel0);
    repeat (3) @(negedge clk);
    chk(upd_ready == 1, "R2 busy beat not taken", upd_ready, 1);
    chk(bank_sel != sel0, "R2 single swap", bank_sel, !sel0);
    measure("R2 rate of first beat", 1, 1, 2, 2);

    // R3 in place, R6 fallback, R8 stays on reference while disabled.
    @(negedge clk);
    out_en = 1'b0;
    repeat (4) @(negedge clk);
    sel0 = bank_sel;
    send(3'd7, 1, 1, 3);
    begin
      int k = 0;
      bit on = 1'b0;
      while (!upd_ready && k < 5000) begin
        @(negedge clk);
        if (mux_on_mn) on = 1'b1;
        k++;
      end
      chk(!on, "R8 no divided path while disabled", on, 0);
    end
    chk(bank_sel == sel0, "R3 disabled update keeps select", bank_sel, sel0);
    chk(act_src_idx == 0, "R6 unknown code falls back to index 0", act_src_idx, 0);
    out_en = 1'b1;
    begin
      int k = 0;
      while (!mux_on_mn && k < 500) begin @(negedge clk); k++; end
    end
    chk(mux_on_mn == 1, "R10 enable after in-place update", mux_on_mn, 1);
    measure("R6 fallback source rate", 1, 1, 3, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule